// File: doc/BRIEF.md
# MII Carrier Sense and Collision Generator

This block drives the carrier sense and collision outputs that a dual-speed Ethernet PHY presents to its MAC. It takes internal level indications (transmit active, receive active and the medium's signal-detect status), along with static mode controls: line speed, duplex, repeater or node operation, a symbol mode and a heartbeat enable bit that the management register file supplies. It combines them into the carrier and collision levels that each mode calls for. All inputs share a single reference clock. Both outputs are registered, so each one follows its inputs with one clock of latency.

At 10 Mb/s, in half duplex node operation, the block can also produce the signal quality error test pulse. After each transmission ends, collision is raised for a fixed number of reference clock cycles, set by the parameter `HB_CYCLES` (25 cycles at 25 MHz gives 1 µs). If a new transmission starts during this pulse, or if the mode leaves the set that allows a heartbeat, the pulse ends early.

Top module: `mii_crs_col`

## Requirements
- R1: In half duplex node mode with symbol mode off, `crs` equals `tx_act | rx_act` as sampled at the previous clock edge.
- R2: With symbol mode off and either `full_dup` or `rptr_mode` high, `crs` equals the previous cycle's `rx_act`, and transmit activity has no effect on it.
- R3: With `sym_mode` high, `crs` equals the previous cycle's `sig_det`, whatever the other modes and activity inputs are.
- R4: In half duplex (`full_dup` = 0), `col` is high in the cycle after one in which `tx_act` and `rx_act` were both high.
- R5: With `full_dup` high, `col` is 0 in the next cycle at either speed, and no heartbeat follows the end of a transmission.
- R6: When `spd_100` = 0, `full_dup` = 0, `rptr_mode` = 0 and `hb_en` = 1, a 1-to-0 change of `tx_act` makes `col` high for exactly `HB_CYCLES` consecutive cycles. The pulse starts one cycle after the first cycle in which `tx_act` is seen low.
- R7: With `rptr_mode` high, `col` is driven only by simultaneous transmit and receive activity. No heartbeat appears, even when `hb_en` = 1.
- R8: With `spd_100` = 1, or with `hb_en` = 0, the end of a transmission produces no heartbeat.
- R9: If `tx_act` rises during a heartbeat pulse, the pulse ends and `col` follows `tx_act & rx_act` from the next cycle onward.
- R10: While `rst` is high, the next clock edge drives `crs` and `col` low and discards any pending heartbeat.
- R11: If the mode leaves the heartbeat-capable set of R6 during a pulse, the pulse ends. After that, `col` follows the collision rule of the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_act | input | 1 | Transmit activity level |
| rx_act | input | 1 | Receive activity level |
| sig_det | input | 1 | Medium signal-detect status, active high |
| spd_100 | input | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| full_dup | input | 1 | 1 selects full duplex |
| rptr_mode | input | 1 | 1 selects repeater operation |
| sym_mode | input | 1 | 1 makes carrier sense report signal detect |
| hb_en | input | 1 | Heartbeat enable bit from management |
| crs | output | 1 | Registered carrier sense |
| col | output | 1 | Registered collision, including the heartbeat pulse |

## Verification
The assertions assume that the mode inputs and activity levels are synchronous to `clk`, so each value sampled at an edge is settled. They also assume that `HB_CYCLES` is at least 1. The bench changes every input only on the falling clock edge, and it switches modes between bursts of activity as well as in the middle of a heartbeat pulse. This keeps all stimulus inside those assumptions while still reaching the early-end cases. Mode changes always arrive as whole-cycle levels and never as glitches.

// File: rtl/mii_crs_col_pkg.sv
package mii_crs_col_pkg;

  typedef enum logic [1:0] {
    CRS_SRC_ANY = 2'd0,
    CRS_SRC_RX  = 2'd1,
    CRS_SRC_SD  = 2'd2
  } crs_src_e;

  function automatic logic sqe_allowed(input logic spd_100, input logic full_dup,
                                       input logic rptr_mode, input logic hb_en);
    return !spd_100 && !full_dup && !rptr_mode && hb_en;
  endfunction

endpackage

// File: rtl/csc_crs_sel.sv
module csc_crs_sel
  import mii_crs_col_pkg::*;
(
  input  logic sym_mode,
  input  logic full_dup,
  input  logic rptr_mode,
  input  logic tx_act,
  input  logic rx_act,
  input  logic sig_det,
  output logic crs_next
);

  crs_src_e src;

  always_comb begin
    if (sym_mode)                    src = CRS_SRC_SD;
    else if (full_dup || rptr_mode)  src = CRS_SRC_RX;
    else                             src = CRS_SRC_ANY;
  end

  always_comb begin
    unique case (src)
      CRS_SRC_SD:  crs_next = sig_det;
      CRS_SRC_RX:  crs_next = rx_act;
      default:     crs_next = tx_act | rx_act;
    endcase
  end

endmodule

// File: rtl/csc_sqe_timer.sv
module csc_sqe_timer
  import mii_crs_col_pkg::*;
#(
  parameter int HB_CYCLES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_act,
  input  logic spd_100,
  input  logic full_dup,
  input  logic rptr_mode,
  input  logic hb_en,
  output logic hb_on
);

  localparam int CW = $clog2(HB_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(HB_CYCLES - 1);

  logic          tx_d;
  logic [CW-1:0] remain;
  logic          armed;
  logic          tx_fall;

  assign armed   = sqe_allowed(spd_100, full_dup, rptr_mode, hb_en);
  assign tx_fall = tx_d && !tx_act;
  assign hb_on   = armed && !tx_act && (tx_fall || (remain != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_d   <= 1'b0;
      remain <= '0;
    end else begin
      tx_d <= tx_act;
      if (tx_act || !armed)
        remain <= '0;
      else if (tx_fall)
        remain <= LOAD;
      else if (remain != '0)
        remain <= remain - 1'b1;
    end
  end

endmodule

// File: rtl/csc_col_sel.sv
module csc_col_sel (
  input  logic full_dup,
  input  logic tx_act,
  input  logic rx_act,
  input  logic hb_on,
  output logic col_next
);

  always_comb begin
    if (full_dup) col_next = 1'b0;
    else          col_next = (tx_act && rx_act) || hb_on;
  end

endmodule

// File: rtl/mii_crs_col.sv
module mii_crs_col
#(
  parameter int HB_CYCLES = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_act,
  input  logic rx_act,
  input  logic sig_det,
  input  logic spd_100,
  input  logic full_dup,
  input  logic rptr_mode,
  input  logic sym_mode,
  input  logic hb_en,
  output logic crs,
  output logic col
);

  logic crs_next;
  logic col_next;
  logic hb_on;

  csc_crs_sel u_crs (
    .sym_mode (sym_mode),
    .full_dup (full_dup),
    .rptr_mode(rptr_mode),
    .tx_act   (tx_act),
    .rx_act   (rx_act),
    .sig_det  (sig_det),
    .crs_next (crs_next)
  );

  csc_sqe_timer #(.HB_CYCLES(HB_CYCLES)) u_sqe (
    .clk      (clk),
    .rst      (rst),
    .tx_act   (tx_act),
    .spd_100  (spd_100),
    .full_dup (full_dup),
    .rptr_mode(rptr_mode),
    .hb_en    (hb_en),
    .hb_on    (hb_on)
  );

  csc_col_sel u_col (
    .full_dup(full_dup),
    .tx_act  (tx_act),
    .rx_act  (rx_act),
    .hb_on   (hb_on),
    .col_next(col_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crs <= 1'b0;
      col <= 1'b0;
    end else begin
      crs <= crs_next;
      col <= col_next;
    end
  end

endmodule

// File: rtl/mii_crs_col_chk.sv
module mii_crs_col_chk (
  input logic clk,
  input logic rst,
  input logic tx_act,
  input logic rx_act,
  input logic sig_det,
  input logic spd_100,
  input logic full_dup,
  input logic rptr_mode,
  input logic sym_mode,
  input logic hb_en,
  input logic crs,
  input logic col
);

  AST_HALF_CRS: assert property (@(posedge clk) disable iff (rst)
    (!sym_mode && !full_dup && !rptr_mode) |=> (crs == ($past(tx_act) | $past(rx_act)))); // R1

  AST_RX_ONLY_CRS: assert property (@(posedge clk) disable iff (rst)
    (!sym_mode && (full_dup || rptr_mode)) |=> (crs == $past(rx_act))); // R2

  AST_SYM_CRS: assert property (@(posedge clk) disable iff (rst)
    sym_mode |=> (crs == $past(sig_det))); // R3

  AST_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    (!full_dup && tx_act && rx_act) |=> col); // R4

  AST_FD_NO_COL: assert property (@(posedge clk) disable iff (rst)
    full_dup |=> !col); // R5

  AST_RPTR_NO_HB: assert property (@(posedge clk) disable iff (rst)
    (rptr_mode && !(tx_act && rx_act)) |=> !col); // R7

  AST_FAST_NO_HB: assert property (@(posedge clk) disable iff (rst)
    ((spd_100 || !hb_en) && !(tx_act && rx_act)) |=> !col); // R8

  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (!crs && !col)); // R10

endmodule

bind mii_crs_col mii_crs_col_chk u_chk (.*);

// File: tb/sim_mii_crs_col.sv
module sim_mii_crs_col;

  localparam int HB = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_act = 0, rx_act = 0, sig_det = 0;
  logic spd_100 = 0, full_dup = 0, rptr_mode = 0, sym_mode = 0, hb_en = 0;
  logic crs, col;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mii_crs_col #(.HB_CYCLES(HB)) u0 (
    .clk(clk), .rst(rst), .tx_act(tx_act), .rx_act(rx_act), .sig_det(sig_det),
    .spd_100(spd_100), .full_dup(full_dup), .rptr_mode(rptr_mode),
    .sym_mode(sym_mode), .hb_en(hb_en), .crs(crs), .col(col)
  );

  // behavioural reference
  logic  e_crs = 0, e_col = 0;
  int    hb_left = 0;
  logic  prev_tx = 0;
  string crs_tag = "R10", col_tag = "R10";

  always @(posedge clk) begin
    bit can_hb;
    if (rst) begin
      e_crs = 0; e_col = 0; hb_left = 0; prev_tx = 0;
      crs_tag = "R10"; col_tag = "R10";
    end else begin
      can_hb = !spd_100 && !full_dup && !rptr_mode && hb_en;
      if (sym_mode)                   begin e_crs = sig_det;         crs_tag = "R3"; end
      else if (full_dup || rptr_mode) begin e_crs = rx_act;          crs_tag = "R2"; end
      else                            begin e_crs = tx_act | rx_act; crs_tag = "R1"; end
      if (tx_act || !can_hb) hb_left = 0;
      else if (prev_tx && !tx_act) hb_left = HB;
      if (full_dup) begin e_col = 0; col_tag = "R5"; end
      else begin
        e_col = (tx_act && rx_act) || (hb_left > 0);
        col_tag = (hb_left > 0) ? "R6" : "R4";
      end
      if (hb_left > 0) hb_left--;
      prev_tx = tx_act;
    end
    #2;
    checks++;
    if (crs !== e_crs) begin
      errors++;
      $display("FAIL %s crs: actual %b expected %b at %0t", crs_tag, crs, e_crs, $time);
    end
    checks++;
    if (col !== e_col) begin
      errors++;
      $display("FAIL %s col: actual %b expected %b at %0t", col_tag, col, e_col, $time);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_col(input int n, input int exp, input string tag);
    int c = 0;
    repeat (n) begin
      @(negedge clk);
      if (col) c++;
    end
    checks++;
    if (c != exp) begin
      errors++;
      $display("FAIL %s col high cycles: actual %0d expected %0d", tag, c, exp);
    end
  endtask

  task automatic set_mode(input logic s100, input logic fd, input logic rp,
                          input logic sy, input logic he);
    spd_100 = s100; full_dup = fd; rptr_mode = rp; sym_mode = sy; hb_en = he;
  endtask

  initial begin
    // R10: reset with activity present
    tx_act = 1; rx_act = 1; sig_det = 1;
    cyc(4);
    tx_act = 0; rx_act = 0; sig_det = 0;
    rst = 0;
    cyc(2);

    // R1, R4: half duplex node, heartbeat off
    set_mode(0, 0, 0, 0, 0);
    tx_act = 1; cyc(3);
    rx_act = 1; cyc(3);
    tx_act = 0; cyc(3);
    rx_act = 0; cyc(3);

    // R8: hb_en clear at 10 Mb/s
    tx_act = 1; cyc(4); tx_act = 0;
    count_col(HB + 10, 0, "R8");

    // R6: heartbeat length
    set_mode(0, 0, 0, 0, 1);
    tx_act = 1; cyc(6); tx_act = 0;
    count_col(HB + 10, HB, "R6");

    // R8: 100 Mb/s no heartbeat
    set_mode(1, 0, 0, 0, 1);
    tx_act = 1; rx_act = 1; cyc(3); rx_act = 0; cyc(2); tx_act = 0;
    count_col(HB + 10, 0, "R8");

    // R2, R5: full duplex
    set_mode(0, 1, 0, 0, 1);
    tx_act = 1; cyc(3); rx_act = 1; cyc(3);
    tx_act = 0; count_col(HB + 5, 0, "R5");
    rx_act = 0; cyc(2);

    // R2, R7: repeater
    set_mode(0, 0, 1, 0, 1);
    tx_act = 1; cyc(3); rx_act = 1; cyc(3); rx_act = 0; cyc(2);
    tx_act = 0; count_col(HB + 5, 0, "R7");

    // R3: symbol mode overrides
    set_mode(0, 0, 0, 1, 0);
    tx_act = 1; rx_act = 1; cyc(2);
    sig_det = 1; cyc(3); tx_act = 0; rx_act = 0; cyc(2);
    sig_det = 0; cyc(3);

    // R9: transmit restarts during a pulse
    set_mode(0, 0, 0, 0, 1);
    tx_act = 1; cyc(4); tx_act = 0; cyc(5);
    tx_act = 1; rx_act = 1; cyc(3);
    rx_act = 0; count_col(4, 0, "R9");
    tx_act = 0; count_col(HB + 5, HB, "R9");

    // R11: mode leaves heartbeat set mid-pulse
    tx_act = 1; cyc(4); tx_act = 0; cyc(6);
    rptr_mode = 1; count_col(HB + 5, 0, "R11");
    rptr_mode = 0; cyc(2);

    // R10: reset mid-pulse
    tx_act = 1; cyc(4); tx_act = 0; cyc(5);
    rst = 1; cyc(2); rst = 0;
    count_col(HB + 5, 0, "R10");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule